// File: doc/BRIEF.md
# Animated Sprite Compositor

This block draws a small set of rectangular, animated sprites on top of a raster scan and merges them into a single pixel stream. Each cycle it receives the scan coordinates of the current pixel. Every sprite decides whether that pixel falls inside its 32×32 bounding box. If so, it looks up one bit of its monochrome bitmap, and a set bit makes the sprite show its colour. A cleared bit, or a pixel outside the box, gives zero, which means transparent.

Each sprite stores sixteen animation frames in a private memory. That memory is filled through a shared write port. The merge stage passes on the colour of the frontmost opaque sprite. It also records whether two sprites were opaque on the same pixel during the current frame.

Game logic drives the position, colour, mirror and frame-advance inputs at any time. The sprites copy them into their working registers only on the cycle marked as the start of vertical retrace. A picture being drawn therefore never shows a half-moved sprite or a frame change partway down the screen.

Top module: `sprite_compositor`

## Requirements
- R1: While `rst_n` is low at a clock edge, `rgb_out` becomes 0 and `collision` becomes 0 after that edge. All sprite positions, colours, mirror bits and frame numbers also return to 0.
- R2: The bitmap row word at write address `{frame, row}` (frame in the upper 4 bits, row in the lower 5) holds bit c for column c. When the scan point is inside a sprite's box and the selected bit is set, the sprite shows its active colour. `rgb_out` carries the result one clock after `hcount`/`vcount` are presented.
- R3: A sprite is transparent (gives 0) when `hcount - x < 0`, `hcount - x >= 32`, `vcount - y < 0`, `vcount - y >= 32`, or its bitmap bit is clear. When every sprite is transparent, `rgb_out` is 0.
- R4: When a sprite's mirror bit is 1, column c of its box reads bitmap bit 31-c instead of bit c.
- R5: Changes to position, colour and mirror inputs have no effect on the picture until a cycle with `vblank_start` high. The values present on that cycle are then used from the next cycle on.
- R6: A one-cycle pulse on a sprite's `next_frame` bit marks that sprite for a frame advance. At the next `vblank_start` its frame number steps by exactly one, however many pulses arrived, and it wraps from 15 to 0. The frame number never changes on any other cycle.
- R7: Sprite 0 is frontmost and higher indices lie behind. `rgb_out` takes the colour of the lowest-numbered opaque sprite.
- R8: At each `vblank_start`, `collision` is loaded with 1 if, since the previous `vblank_start`, any scanned pixel had two or more opaque sprites, and with 0 otherwise. It holds that value until the next `vblank_start`.
- R9: A write with `wr_en` high stores `wr_data` into the bitmap of sprite `wr_sel` at `wr_addr`. The picture uses the new data from the next clock on, while other sprites' bitmaps stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hcount | input | 11 | Horizontal scan position of the current pixel |
| vcount | input | 10 | Vertical scan position of the current pixel |
| vblank_start | input | 1 | One-cycle marker for the start of vertical retrace |
| xpos_all | input | 33 | Left edge of each sprite, 11 bits per sprite, sprite 0 in the low bits |
| ypos_all | input | 30 | Top edge of each sprite, 10 bits per sprite |
| color_all | input | 24 | Colour of each sprite, 8 bits per sprite |
| mirror_all | input | 3 | Horizontal mirror bit per sprite |
| next_frame_all | input | 3 | Frame-advance request per sprite |
| wr_en | input | 1 | Bitmap write strobe |
| wr_sel | input | 2 | Sprite whose bitmap is written |
| wr_addr | input | 9 | Bitmap row address {frame, row} |
| wr_data | input | 32 | Bitmap row word, bit c is column c |
| rgb_out | output | 8 | Merged pixel colour, 0 when nothing is opaque |
| collision | output | 1 | Overlap status of the previous frame |

## Verification
The hardest condition to reach from the ports is an update that must not take effect yet. Examples are a sprite moved in mid-frame, several frame-advance pulses inside one frame, and a frame number going past 15. The bench places these requests on ordinary scan cycles and probes the old location and old frame before any retrace marker arrives. It then issues the marker and probes the new ones. For collisions, the bench stacks three sprites with pseudo-random bitmaps over one region and scans it pixel by pixel. It predicts from its own bitmap copy whether any pixel had two opaque sprites, and checks that the status shows the overlap in one frame and clears in the next frame, which has no overlap.

// File: rtl/sprite_pkg.sv
package sprite_pkg;

  // Scan coordinate lies in [org, org+side)
  function automatic logic box_hit(input logic [15:0] scan, input logic [15:0] org,
                                   input logic [15:0] side);
    return (scan >= org) && ((scan - org) < side);
  endfunction

  // Column index into the bitmap row, optionally reversed
  function automatic logic [15:0] col_pick(input logic [15:0] dx, input logic mirror,
                                           input logic [15:0] side);
    return mirror ? (side - 16'd1 - dx) : dx;
  endfunction

  // More than one bit set
  function automatic logic multi_hot(input logic [31:0] v);
    return (v & (v - 32'd1)) != 32'd0;
  endfunction

endpackage

// File: rtl/sprite_store.sv
module sprite_store #(
  parameter int SIDE_LOG2  = 5,
  parameter int FRAME_LOG2 = 4
) (
  input  logic                                clk,
  input  logic                                wr_en,
  input  logic [FRAME_LOG2+SIDE_LOG2-1:0]     wr_addr,
  input  logic [(1<<SIDE_LOG2)-1:0]           wr_data,
  input  logic [FRAME_LOG2+SIDE_LOG2-1:0]     rd_addr,
  output logic [(1<<SIDE_LOG2)-1:0]           rd_data
);
  localparam int SIDE  = 1 << SIDE_LOG2;
  localparam int AW    = FRAME_LOG2 + SIDE_LOG2;
  localparam int DEPTH = 1 << AW;

  logic [SIDE-1:0] rows [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) rows[wr_addr] <= wr_data;
  end

  assign rd_data = rows[rd_addr];
endmodule

// File: rtl/sprite_unit.sv
module sprite_unit
  import sprite_pkg::*;
#(
  parameter int HW         = 11,
  parameter int VW         = 10,
  parameter int CW         = 8,
  parameter int SIDE_LOG2  = 5,
  parameter int FRAME_LOG2 = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [HW-1:0]                     hcount,
  input  logic [VW-1:0]                     vcount,
  input  logic                              frame_tick,
  input  logic [HW-1:0]                     xpos,
  input  logic [VW-1:0]                     ypos,
  input  logic [CW-1:0]                     color,
  input  logic                              mirror,
  input  logic                              next_frame,
  input  logic                              wr_en,
  input  logic [FRAME_LOG2+SIDE_LOG2-1:0]   wr_addr,
  input  logic [(1<<SIDE_LOG2)-1:0]         wr_data,
  output logic [CW-1:0]                     pix,
  output logic [HW-1:0]                     act_x,
  output logic [VW-1:0]                     act_y,
  output logic [FRAME_LOG2-1:0]             frame_q
);
  localparam int SIDE = 1 << SIDE_LOG2;
  localparam logic [FRAME_LOG2-1:0] LAST_FRAME = FRAME_LOG2'((1 << FRAME_LOG2) - 1);

  logic [CW-1:0] act_col;
  logic          act_mir;
  logic          adv_pend;

  // Working registers refresh only at the retrace marker
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_x    <= '0;
      act_y    <= '0;
      act_col  <= '0;
      act_mir  <= 1'b0;
      frame_q  <= '0;
      adv_pend <= 1'b0;
    end else begin
      if (next_frame) adv_pend <= 1'b1;
      if (frame_tick) begin
        act_x    <= xpos;
        act_y    <= ypos;
        act_col  <= color;
        act_mir  <= mirror;
        adv_pend <= 1'b0;
        if (adv_pend || next_frame)
          frame_q <= (frame_q == LAST_FRAME) ? '0 : frame_q + 1'b1;
      end
    end
  end

  logic [15:0]          dx_w, dy_w, col_w;
  logic                 in_x, in_y;
  logic [SIDE_LOG2-1:0] row_idx, col_idx;
  logic [SIDE-1:0]      row_word;

  assign in_x    = box_hit(16'(hcount), 16'(act_x), 16'(SIDE));
  assign in_y    = box_hit(16'(vcount), 16'(act_y), 16'(SIDE));
  assign dx_w    = 16'(hcount) - 16'(act_x);
  assign dy_w    = 16'(vcount) - 16'(act_y);
  assign col_w   = col_pick(dx_w, act_mir, 16'(SIDE));
  assign row_idx = SIDE_LOG2'(dy_w);
  assign col_idx = SIDE_LOG2'(col_w);

  sprite_store #(.SIDE_LOG2(SIDE_LOG2), .FRAME_LOG2(FRAME_LOG2)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr ({frame_q, row_idx}),
    .rd_data (row_word)
  );

  assign pix = (in_x && in_y && row_word[col_idx]) ? act_col : '0;
endmodule

// File: rtl/sprite_merge.sv
module sprite_merge
  import sprite_pkg::*;
#(
  parameter int NUM_SPR = 3,
  parameter int CW      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    frame_tick,
  input  logic [NUM_SPR*CW-1:0]   pix_flat,
  output logic [NUM_SPR-1:0]      opaque_vec,
  output logic                    hit_now,
  output logic                    coll_live,
  output logic                    coll_stat,
  output logic [CW-1:0]           rgb_out
);
  logic [CW-1:0] pick;

  for (genvar i = 0; i < NUM_SPR; i++) begin : g_opq
    assign opaque_vec[i] = |pix_flat[i*CW +: CW];
  end

  // Scan back to front so the lowest index overrides
  always_comb begin
    pick = '0;
    for (int i = NUM_SPR - 1; i >= 0; i--) begin
      if (opaque_vec[i]) pick = pix_flat[i*CW +: CW];
    end
  end

  assign hit_now = multi_hot(32'(opaque_vec));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb_out   <= '0;
      coll_live <= 1'b0;
      coll_stat <= 1'b0;
    end else begin
      rgb_out <= pick;
      if (frame_tick) begin
        coll_stat <= coll_live | hit_now;
        coll_live <= 1'b0;
      end else if (hit_now) begin
        coll_live <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sprite_compositor.sv
module sprite_compositor #(
  parameter int NUM_SPR    = 3,
  parameter int HW         = 11,
  parameter int VW         = 10,
  parameter int CW         = 8,
  parameter int SIDE_LOG2  = 5,
  parameter int FRAME_LOG2 = 4,
  localparam int SEL_W     = (NUM_SPR > 1) ? $clog2(NUM_SPR) : 1,
  localparam int AW        = FRAME_LOG2 + SIDE_LOG2,
  localparam int SIDE      = 1 << SIDE_LOG2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [HW-1:0]           hcount,
  input  logic [VW-1:0]           vcount,
  input  logic                    vblank_start,
  input  logic [NUM_SPR*HW-1:0]   xpos_all,
  input  logic [NUM_SPR*VW-1:0]   ypos_all,
  input  logic [NUM_SPR*CW-1:0]   color_all,
  input  logic [NUM_SPR-1:0]      mirror_all,
  input  logic [NUM_SPR-1:0]      next_frame_all,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        wr_sel,
  input  logic [AW-1:0]           wr_addr,
  input  logic [SIDE-1:0]         wr_data,
  output logic [CW-1:0]           rgb_out,
  output logic                    collision
);
  // Named internal events, observed by the bound checker
  logic [NUM_SPR*CW-1:0]         spr_pix_flat;
  logic [NUM_SPR*HW-1:0]         act_x_flat;
  logic [NUM_SPR*VW-1:0]         act_y_flat;
  logic [NUM_SPR*FRAME_LOG2-1:0] frame_flat;
  logic [NUM_SPR-1:0]            opaque_vec;
  logic                          hit_now;
  logic                          coll_live;

  for (genvar i = 0; i < NUM_SPR; i++) begin : g_spr
    sprite_unit #(
      .HW(HW), .VW(VW), .CW(CW), .SIDE_LOG2(SIDE_LOG2), .FRAME_LOG2(FRAME_LOG2)
    ) u_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .hcount     (hcount),
      .vcount     (vcount),
      .frame_tick (vblank_start),
      .xpos       (xpos_all[i*HW +: HW]),
      .ypos       (ypos_all[i*VW +: VW]),
      .color      (color_all[i*CW +: CW]),
      .mirror     (mirror_all[i]),
      .next_frame (next_frame_all[i]),
      .wr_en      (wr_en && (wr_sel == SEL_W'(i))),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .pix        (spr_pix_flat[i*CW +: CW]),
      .act_x      (act_x_flat[i*HW +: HW]),
      .act_y      (act_y_flat[i*VW +: VW]),
      .frame_q    (frame_flat[i*FRAME_LOG2 +: FRAME_LOG2])
    );
  end

  sprite_merge #(.NUM_SPR(NUM_SPR), .CW(CW)) u_merge (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_tick (vblank_start),
    .pix_flat   (spr_pix_flat),
    .opaque_vec (opaque_vec),
    .hit_now    (hit_now),
    .coll_live  (coll_live),
    .coll_stat  (collision),
    .rgb_out    (rgb_out)
  );
endmodule

// File: rtl/sprite_compositor_chk.sv
module sprite_compositor_chk #(
  parameter int NUM_SPR    = 3,
  parameter int HW         = 11,
  parameter int VW         = 10,
  parameter int CW         = 8,
  parameter int FRAME_LOG2 = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          vblank_start,
  input logic [CW-1:0]                 rgb_out,
  input logic                          collision,
  input logic [CW-1:0]                 front_pix,
  input logic [NUM_SPR-1:0]            opaque_vec,
  input logic                          hit_now,
  input logic                          coll_live,
  input logic [NUM_SPR*HW-1:0]         act_x_flat,
  input logic [NUM_SPR*VW-1:0]         act_y_flat,
  input logic [NUM_SPR*FRAME_LOG2-1:0] frame_flat
);
  p_reset_out_r1: assert property (@(posedge clk)
    !rst_n |=> (rgb_out == '0 && !collision));

  p_front_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    opaque_vec[0] |=> (rgb_out == $past(front_pix)));

  p_all_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (opaque_vec == '0) |=> (rgb_out == '0));

  p_pos_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> ($stable(act_x_flat) && $stable(act_y_flat)));

  p_frame_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> $stable(frame_flat));

  p_overlap_seen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_now && !vblank_start) |=> coll_live);

  p_status_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !vblank_start |=> $stable(collision));
endmodule

bind sprite_compositor sprite_compositor_chk #(
  .NUM_SPR(NUM_SPR), .HW(HW), .VW(VW), .CW(CW), .FRAME_LOG2(FRAME_LOG2)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .vblank_start (vblank_start),
  .rgb_out      (rgb_out),
  .collision    (collision),
  .front_pix    (spr_pix_flat[CW-1:0]),
  .opaque_vec   (opaque_vec),
  .hit_now      (hit_now),
  .coll_live    (coll_live),
  .act_x_flat   (act_x_flat),
  .act_y_flat   (act_y_flat),
  .frame_flat   (frame_flat)
);

// File: tb/tb_sprite_compositor.sv
`timescale 1ns/1ps
module tb_sprite_compositor;
  localparam int N = 3, HW = 11, VW = 10, CW = 8, SL = 5, FL = 4;
  localparam int SIDE = 32, AW = 9, ROWS = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [HW-1:0] hcount = '1;
  logic [VW-1:0] vcount = '1;
  logic vblank_start = 1'b0;
  logic [N*HW-1:0] xpos_all = '0;
  logic [N*VW-1:0] ypos_all = '0;
  logic [N*CW-1:0] color_all = '0;
  logic [N-1:0] mirror_all = '0, next_frame_all = '0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [SIDE-1:0] wr_data = '0;
  logic [CW-1:0] rgb_out;
  logic collision;

  sprite_compositor dut (.*);

  always #2 clk = ~clk;

  // Bench-side model of the requirements
  logic [31:0] bm [N][ROWS];
  int px[N], py[N], pc[N]; bit pm[N];   // requested
  int mx[N], my[N], mc[N]; bit mm[N];   // active
  int mf[N]; bit npend[N];
  bit coll_model, coll_expect;
  int checks = 0, errors = 0;
  int exp_q[$]; string tag_q[$];

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ref_pix(int h, int v, output int nop);
    int res = 0; nop = 0;
    for (int s = N - 1; s >= 0; s--) begin
      int dx = h - mx[s], dy = v - my[s];
      if (dx >= 0 && dx < SIDE && dy >= 0 && dy < SIDE) begin
        int c = mm[s] ? (SIDE - 1 - dx) : dx;
        if (bm[s][mf[s]*SIDE + dy][c] && mc[s] != 0) begin
          res = mc[s]; nop++;
        end
      end
    end
    return res;
  endfunction

  function automatic logic [31:0] pat(int s, int f, int r);
    return (32'h9E3779B9 * 32'(s*512 + f*32 + r + 7)) ^ (32'h1 << r);
  endfunction

  // Driver: present a scan point and queue the expected colour
  task automatic probe(int h, int v, string tag);
    int e, n;
    @(negedge clk);
    hcount = HW'(h); vcount = VW'(v);
    e = ref_pix(h, v, n);
    if (n > 1) coll_model = 1;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic scan(int x0, int y0, int w, int h, string tag);
    for (int y = y0; y < y0 + h; y++)
      for (int x = x0; x < x0 + w; x++) probe(x, y, tag);
  endtask

  // Monitor: compare one cycle after presentation
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      int e; string t;
      e = exp_q.pop_front(); t = tag_q.pop_front();
      check(rgb_out == CW'(e), t, int'(rgb_out), e);
    end
  end

  task automatic set_spr(int s, int x, int y, int c, bit m);
    @(negedge clk);
    xpos_all[s*HW +: HW] = HW'(x); ypos_all[s*VW +: VW] = VW'(y);
    color_all[s*CW +: CW] = CW'(c); mirror_all[s] = m;
    px[s] = x; py[s] = y; pc[s] = c; pm[s] = m;
  endtask

  task automatic vsync();
    @(negedge clk);
    hcount = '1; vcount = '1; vblank_start = 1'b1;
    coll_expect = coll_model; coll_model = 0;
    for (int s = 0; s < N; s++) begin
      mx[s] = px[s]; my[s] = py[s]; mc[s] = pc[s]; mm[s] = pm[s];
      if (npend[s]) mf[s] = (mf[s] + 1) % 16;
      npend[s] = 0;
    end
    @(negedge clk);
    vblank_start = 1'b0;
  endtask

  task automatic frame_pulse(int s);
    @(negedge clk);
    next_frame_all[s] = 1'b1; npend[s] = 1;
    @(negedge clk);
    next_frame_all[s] = 1'b0;
  endtask

  task automatic write_row(int s, int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'(s); wr_addr = AW'(a); wr_data = d;
    bm[s][a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
  end

  initial begin
    for (int s = 0; s < N; s++) begin
      px[s] = 0; py[s] = 0; pc[s] = 0; pm[s] = 0;
      mx[s] = 0; my[s] = 0; mc[s] = 0; mm[s] = 0; mf[s] = 0; npend[s] = 0;
    end
    coll_model = 0; coll_expect = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(rgb_out == '0, "R1 rgb after reset", int'(rgb_out), 0);
    check(collision == 1'b0, "R1 collision after reset", int'(collision), 0);
    rst_n = 1'b1;

    // R9: load every bitmap through the write port
    for (int s = 0; s < N; s++)
      for (int a = 0; a < ROWS; a++) begin
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 2'(s); wr_addr = AW'(a);
        wr_data = pat(s, a / 32, a % 32); bm[s][a] = pat(s, a / 32, a % 32);
      end
    @(negedge clk); wr_en = 1'b0;

    set_spr(0, 100, 50, 5, 0);
    set_spr(1, 300, 300, 9, 1);
    set_spr(2, 600, 400, 12, 0);
    // R5: requests not yet applied, picture stays blank
    probe(110, 60, "R5 before retrace");
    probe(5, 5, "R5 before retrace origin");
    vsync();
    check(collision == coll_expect, "R8 no overlap frame", int'(collision), int'(coll_expect));

    scan(98, 48, 36, 36, "R2 R3 sprite0 box and edges");
    scan(298, 298, 36, 36, "R4 mirrored sprite1");
    scan(598, 398, 36, 4, "R3 sprite2 top edge");

    // R5: move sprite0 mid-frame, old place still drawn
    set_spr(0, 200, 50, 7, 0);
    scan(98, 50, 36, 2, "R5 old position holds");
    vsync();
    scan(98, 50, 36, 2, "R5 old position vacated");
    scan(198, 48, 36, 36, "R5 new position");

    // R6: two pulses, one step
    frame_pulse(0); frame_pulse(0);
    scan(200, 50, 32, 4, "R6 frame not yet stepped");
    vsync();
    scan(198, 48, 36, 36, "R6 frame one");
    for (int k = 0; k < 15; k++) begin
      frame_pulse(0); vsync();
    end
    scan(198, 48, 36, 36, "R6 wrap to frame zero");
    scan(298, 298, 36, 4, "R6 sprite1 frame untouched");

    // R7 and R8: stack three sprites
    set_spr(1, 210, 60, 9, 1);
    set_spr(2, 215, 65, 12, 0);
    vsync();
    coll_model = 0;
    scan(198, 48, 52, 52, "R7 priority overlap");
    vsync();
    check(collision == coll_expect, "R8 overlap frame", int'(collision), int'(coll_expect));
    check(coll_expect == 1'b1, "R8 overlap expected", int'(coll_expect), 1);
    vsync();
    check(collision == 1'b0, "R8 clear next frame", int'(collision), 0);

    // R9: runtime rewrite of one row of sprite0 frame 0
    write_row(0, 3, 32'hFFFF_0000);
    scan(200, 53, 32, 1, "R9 rewritten row");
    scan(210, 63, 32, 1, "R9 sprite1 row unchanged");

    repeat (4) @(posedge clk);
    #2;
    report();
  end
endmodule